// File: doc/BRIEF.md
# Dual-Channel GCI Time-Slot Serializer

This block carries two 8-bit voice samples per 8 kHz frame between parallel channel registers and a serial line. The serial line uses GCI-style timing. It runs directly on the line's bit clock. A one-cycle frame-sync pulse marks the start of each 125 µs frame. Each serial data bit lasts two bit-clock periods, so the 8-bit slot B1 fills bit-clock cycles 0 to 15 of the frame and slot B2 fills cycles 16 to 31. The rest of the frame is idle. A frame can be as long as the slowest permitted bit clock allows.

At the start of each frame the block takes both transmit samples, raises a one-cycle ready strobe, and shifts the samples out most-significant bit first on the serial output. The output-enable is high only while the two voice slots are on the line. Receive bits are sampled near the end of each bit period. Each channel's byte is presented on its parallel output with a one-cycle valid strobe as soon as its slot ends. A swap input decides which analog channel uses which slot. The block captures that input at each frame start.

Top module: `gci_slot_serializer`

## Requirements
- R1: While reset is asserted and after it is released, these outputs are low or zero: `dxOe`, `txReady`, both receive valid strobes and both receive bytes. They stay so until the first frame-sync rising edge.
- R2: A frame starts on the bit-clock edge at which `fs` is first seen high. A frame sync held high for a second cycle does not restart the frame.
- R3: `txReady` is high for exactly the one bit-clock cycle after the frame-start edge. Both transmit bytes are captured at that edge, so later changes to `txData0` or `txData1` do not affect the current frame.
- R4: Counting bit-clock cycles from 0 after the frame-start edge, `dx` carries serial bit j (j = 0..15) in cycles 2j and 2j+1. Bits 0..7 are the B1 byte and bits 8..15 are the B2 byte, each most-significant bit first.
- R5: `dxOe` is high in frame cycles 0 to 31 and low in every other cycle, including before the first frame.
- R6: With the swap value captured at frame start equal to 0, channel 0 uses slot B1 and channel 1 uses slot B2, for both directions. With it equal to 1, the two channels trade slots.
- R7: `dr` is sampled on the falling bit-clock edge inside cycle 2j+1 of each bit period. The value present during cycle 2j has no effect. Bits arrive most-significant bit first.
- R8: The byte received in B1 appears on the output of the channel mapped to B1, and that channel's valid strobe is high for frame cycle 16 only. The B2 byte and its channel's strobe follow in frame cycle 32.
- R9: `dr` activity in frame cycles 32 and later changes no receive byte and raises no valid strobe.
- R10: Frames of any length of at least 34 bit-clock cycles are handled. A new frame-sync rising edge always restarts the cycle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock of the serial line |
| rstN | input | 1 | Asynchronous active-low reset |
| fs | input | 1 | Frame sync, one bit-clock period high per frame |
| swapSlots | input | 1 | 0: ch0 uses B1 and ch1 uses B2; 1: the two are exchanged |
| txData0 | input | 8 | Transmit sample, channel 0 |
| txData1 | input | 8 | Transmit sample, channel 1 |
| txReady | output | 1 | One-cycle strobe: transmit samples taken for this frame |
| dx | output | 1 | Serial transmit data |
| dxOe | output | 1 | Drive enable for dx |
| dr | input | 1 | Serial receive data |
| rxData0 | output | 8 | Last received sample, channel 0 |
| rxData1 | output | 8 | Last received sample, channel 1 |
| rxValid0 | output | 1 | One-cycle strobe: rxData0 updated |
| rxValid1 | output | 1 | One-cycle strobe: rxData1 updated |

## Verification
The hardest condition to create from the ports is a receive bit that is correct only at the instant of sampling. The stimulus therefore drives the inverse of each bit during the first cycle of its period and the true value only during the second. A sampler placed on the wrong edge or in the wrong half of the period then collects the wrong byte. Every frame also fills the idle tail with toggling `dr` data, and the bench confirms after each cycle that the stored bytes stay unchanged. The bench sweeps frame lengths, both swap settings and a frame sync held for two cycles, and changes the transmit inputs just after frame start to show they were captured at that edge.

// File: rtl/gci_pkg.sv
package gci_pkg;

  // Per-edge commands issued by the sequencer to the shift datapath.
  typedef struct packed {
    logic load;      // frame start: capture tx bytes and swap, drive first bit
    logic shiftTx;   // start of a new bit period inside the voice slots
    logic oeOff;     // last voice cycle ends at this edge
    logic sampleRx;  // current cycle is the second half of a voice bit
    logic latchB1;   // B1 receive byte complete at this edge
    logic latchB2;   // B2 receive byte complete at this edge
  } gciStrobe_t;

endpackage

// File: rtl/gci_slot_ctrl.sv
module gci_slot_ctrl
  import gci_pkg::*;
#(
  parameter int BIT_W     = 8,
  parameter int FRAME_MAX = 512
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       fs,
  output gciStrobe_t strb,
  output logic       txReady
);

  localparam int POS_W      = $clog2(FRAME_MAX + 1);
  localparam int HALF_CYC   = 2 * BIT_W;
  localparam int ACTIVE_CYC = 2 * HALF_CYC;
  localparam logic [POS_W-1:0] POS_MAX   = POS_W'(FRAME_MAX);
  localparam logic [POS_W-1:0] B1_END    = POS_W'(HALF_CYC - 1);
  localparam logic [POS_W-1:0] B2_END    = POS_W'(ACTIVE_CYC - 1);
  localparam logic [POS_W-1:0] SHIFT_LIM = POS_W'(ACTIVE_CYC - 2);
  localparam logic [POS_W-1:0] ACT_LIM   = POS_W'(ACTIVE_CYC);

  logic             fsPrev;
  logic             active;
  logic [POS_W-1:0] pos;
  logic             fsRise;
  logic             inFrame;

  assign fsRise  = fs && !fsPrev;
  assign inFrame = active && !fsRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fsPrev  <= 1'b0;
      active  <= 1'b0;
      pos     <= '0;
      txReady <= 1'b0;
    end else begin
      fsPrev  <= fs;
      txReady <= fsRise;
      if (fsRise) begin
        active <= 1'b1;
        pos    <= '0;
      end else if (active && pos != POS_MAX) begin
        pos <= pos + 1'b1;
      end
    end
  end

  always_comb begin
    strb          = '0;
    strb.load     = fsRise;
    strb.shiftTx  = inFrame && pos[0] && (pos < SHIFT_LIM);
    strb.oeOff    = inFrame && (pos == B2_END);
    strb.sampleRx = active && pos[0] && (pos < ACT_LIM);
    strb.latchB1  = inFrame && (pos == B1_END);
    strb.latchB2  = inFrame && (pos == B2_END);
  end

  // R10: inside a frame the cycle count advances by one each edge
  a_r10_count_advance: assert property (@(posedge clk) disable iff (!rstN)
    (active && !fsRise && pos != POS_MAX) |=> (pos == $past(pos) + 1'b1));

  // R3: the ready strobe never lasts two cycles
  a_r3_ready_single: assert property (@(posedge clk) disable iff (!rstN)
    txReady |=> !txReady);

  // R2: a held-high frame sync does not restart the count
  a_r2_no_retrigger: assert property (@(posedge clk) disable iff (!rstN)
    (fs && $past(fs) && active && pos != POS_MAX) |=> (pos != '0));

endmodule

// File: rtl/gci_slot_dp.sv
module gci_slot_dp
  import gci_pkg::*;
#(
  parameter int BIT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  gciStrobe_t       strb,
  input  logic             swapSlots,
  input  logic [BIT_W-1:0] txData0,
  input  logic [BIT_W-1:0] txData1,
  input  logic             dr,
  output logic             dx,
  output logic             dxOe,
  output logic [BIT_W-1:0] rxData0,
  output logic [BIT_W-1:0] rxData1,
  output logic             rxValid0,
  output logic             rxValid1
);

  localparam int WORD_W = 2 * BIT_W;
  localparam int CH_N   = 2;

  logic              swapLat;
  logic [WORD_W-1:0] txWord;
  logic [WORD_W-1:0] txSh;
  logic [BIT_W-1:0]  rxSh;

  // B1 byte in the upper half, B2 in the lower half
  assign txWord = swapSlots ? {txData1, txData0} : {txData0, txData1};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swapLat <= 1'b0;
      txSh    <= '0;
      dx      <= 1'b0;
      dxOe    <= 1'b0;
    end else if (strb.load) begin
      swapLat <= swapSlots;
      dx      <= txWord[WORD_W-1];
      txSh    <= {txWord[WORD_W-2:0], 1'b0};
      dxOe    <= 1'b1;
    end else begin
      if (strb.shiftTx) begin
        dx   <= txSh[WORD_W-1];
        txSh <= {txSh[WORD_W-2:0], 1'b0};
      end
      if (strb.oeOff) begin
        dxOe <= 1'b0;
      end
    end
  end

  // Receive sampler on the falling edge inside the second half of a bit
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh <= '0;
    end else if (strb.sampleRx) begin
      rxSh <= {rxSh[BIT_W-2:0], dr};
    end
  end

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    logic             usesB1;
    logic             hit;
    logic [BIT_W-1:0] rxByte;
    logic             rxVld;

    assign usesB1 = (c == 0) ? !swapLat : swapLat;
    assign hit    = usesB1 ? strb.latchB1 : strb.latchB2;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rxByte <= '0;
        rxVld  <= 1'b0;
      end else begin
        rxVld <= hit;
        if (hit) begin
          rxByte <= rxSh;
        end
      end
    end
  end

  assign rxData0  = g_ch[0].rxByte;
  assign rxData1  = g_ch[1].rxByte;
  assign rxValid0 = g_ch[0].rxVld;
  assign rxValid1 = g_ch[1].rxVld;

  // R4: dx holds between bit-period boundaries
  a_r4_dx_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.shiftTx) |=> $stable(dx));

  // R8: the two channels never report in the same cycle
  a_r8_valid_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rxValid0, rxValid1}));

  // R9: a receive strobe only follows a cycle inside the voice window
  a_r9_valid_in_window: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid0 || rxValid1) |-> $past(dxOe));

  // R6: the slot mapping only changes at a frame start
  a_r6_swap_held: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(swapLat));

endmodule

// File: rtl/gci_slot_serializer.sv
module gci_slot_serializer
  import gci_pkg::*;
#(
  parameter int BIT_W     = 8,
  parameter int FRAME_MAX = 512
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fs,
  input  logic             swapSlots,
  input  logic [BIT_W-1:0] txData0,
  input  logic [BIT_W-1:0] txData1,
  output logic             txReady,
  output logic             dx,
  output logic             dxOe,
  input  logic             dr,
  output logic [BIT_W-1:0] rxData0,
  output logic [BIT_W-1:0] rxData1,
  output logic             rxValid0,
  output logic             rxValid1
);

  gciStrobe_t strb;

  gci_slot_ctrl #(.BIT_W(BIT_W), .FRAME_MAX(FRAME_MAX)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .fs      (fs),
    .strb    (strb),
    .txReady (txReady)
  );

  gci_slot_dp #(.BIT_W(BIT_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .swapSlots (swapSlots),
    .txData0   (txData0),
    .txData1   (txData1),
    .dr        (dr),
    .dx        (dx),
    .dxOe      (dxOe),
    .rxData0   (rxData0),
    .rxData1   (rxData1),
    .rxValid0  (rxValid0),
    .rxValid1  (rxValid1)
  );

  // R3: the ready strobe falls in the first voice cycle
  a_r3_ready_in_window: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> dxOe);

  // R5: the drive window opens only right after a frame start
  a_r5_oe_opens_on_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dxOe) |-> txReady);

endmodule

// File: tb/test_gci_slot_serializer.sv
module test_gci_slot_serializer;

  logic       clk;
  logic       rstN;
  logic       fs;
  logic       swapSlots;
  logic [7:0] txData0;
  logic [7:0] txData1;
  logic       txReady;
  logic       dx;
  logic       dxOe;
  logic       dr;
  logic [7:0] rxData0;
  logic [7:0] rxData1;
  logic       rxValid0;
  logic       rxValid1;

  int total = 0;
  int bad   = 0;
  logic [7:0] expRx0 = 8'h00;
  logic [7:0] expRx1 = 8'h00;

  gci_slot_serializer i_gci_slot_serializer (
    .clk(clk), .rstN(rstN), .fs(fs), .swapSlots(swapSlots),
    .txData0(txData0), .txData1(txData1), .txReady(txReady),
    .dx(dx), .dxOe(dxOe), .dr(dr),
    .rxData0(rxData0), .rxData1(rxData1),
    .rxValid0(rxValid0), .rxValid1(rxValid1)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input int p, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s cycle=%0d actual=%0h expected=%0h", req, p, act, exp);
    end
  endtask

  // Called at posedge+1 of the cycle that precedes the frame-start edge.
  task automatic runFrame(input int len, input logic [7:0] t0, input logic [7:0] t1,
                          input logic [7:0] b1, input logic [7:0] b2,
                          input logic sw, input bit fsLong);
    logic [15:0] word;
    logic [15:0] rxw;
    logic        bitv;
    fs = 1'b1; txData0 = t0; txData1 = t1; swapSlots = sw;
    word = sw ? {t1, t0} : {t0, t1};
    rxw  = {b1, b2};
    @(posedge clk); #1;
    if (!fsLong) fs = 1'b0;
    for (int p = 0; p < len; p++) begin
      if (p == 1) begin
        fs = 1'b0;
        // R3: inputs changed after capture must not reach the line
        txData0 = ~t0; txData1 = ~t1; swapSlots = ~sw;
      end
      if (p < 32) begin
        bitv = rxw[15 - p/2];
        dr = p[0] ? bitv : ~bitv;   // R7: wrong value in first half of the bit
      end else begin
        dr = p[0] ^ p[2];           // R9: junk after the voice slots
      end
      #3;
      chk("R3 txReady", p, txReady, (p == 0));
      chk("R5 dxOe", p, dxOe, (p < 32));
      if (p < 32) chk("R4/R6 dx bit", p, dx, word[15 - p/2]);
      if (p == 16) begin
        if (sw) expRx1 = b1; else expRx0 = b1;
      end
      if (p == 32) begin
        if (sw) expRx0 = b2; else expRx1 = b2;
      end
      chk("R8 rxValid0", p, rxValid0, (p == 16 && !sw) || (p == 32 && sw));
      chk("R8 rxValid1", p, rxValid1, (p == 16 && sw) || (p == 32 && !sw));
      chk("R7/R9 rxData0", p, rxData0, expRx0);
      chk("R7/R9 rxData1", p, rxData1, expRx1);
      if (p == 2) chk("R2 held sync no restart", p, dx, word[14]);
      @(posedge clk); #1;
    end
  endtask

  initial begin
    rstN = 1'b0; fs = 1'b0; dr = 1'b0; swapSlots = 1'b0;
    txData0 = 8'h00; txData1 = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 dxOe", 0, dxOe, 0);
    chk("R1 txReady", 0, txReady, 0);
    chk("R1 rxValid", 0, {rxValid0, rxValid1}, 0);
    chk("R1 rxData", 0, {rxData0, rxData1}, 0);
    rstN = 1'b1;
    for (int i = 0; i < 6; i++) begin
      dr = i[0];
      @(posedge clk); #1;
      chk("R5 idle before first frame", i, dxOe, 0);
      chk("R1 no strobes before first frame", i, {txReady, rxValid0, rxValid1}, 0);
    end
    // R10: sweep lengths; R6: both swap settings
    for (int s = 0; s < 2; s++) begin
      for (int k = 0; k < 8; k++) begin
        runFrame(34 + k * 12, 8'(k * 37 + 5), 8'(~(k * 37 + 5)) ^ 8'(k << 4),
                 8'(k * 53) ^ 8'hC3, 8'(1 << k), s[0], (k == 3));
      end
    end
    runFrame(40, 8'hFF, 8'h00, 8'h00, 8'hFF, 1'b0, 1'b0);
    runFrame(300, 8'h80, 8'h01, 8'h01, 8'h80, 1'b1, 1'b1);
    runFrame(34, 8'hA5, 8'h5A, 8'h3C, 8'hC3, 1'b0, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule